// File: doc/BRIEF.md
# SIMT Warp Divergence and Reconvergence Stack

This block tracks which threads of one warp are enabled as the warp passes through conditional branches. All threads of a warp share one program counter while they agree. When a branch splits them, the block runs the taken group first. It keeps a record of the other group and of the point where the two groups meet again. When the running group reaches that meeting point, the block switches to the waiting group. When the waiting group also arrives, the block restores the mask that was active before the split. Nested splits are handled up to a fixed nesting depth. Each warp has its own instance, so the state of one warp never affects another.

The surrounding pipeline feeds the block two streams. The first is a branch event, which carries the per-thread taken mask, the taken target, the fall-through address and the reconvergence address. The second is a stream of sequential next-PC values. The block returns the current PC and the active mask. It pulses a flag each time a reconvergence point moves it to a stored context. If a split arrives while the stack is full, a sticky error flag is raised.

Top module: `simt_div_stack`

## Requirements
- R1: Reset (synchronous, active high) sets the PC to RESET_PC (default 0), the active mask to all ones, and the error flag and the rejoin pulse to 0.
- R2: When a next-PC value is presented and no branch is presented, the PC takes that value one cycle later and the mask is unchanged, unless the value equals the reconvergence address of the path that is running.
- R3: A branch whose effective taken mask equals the active mask sends the PC to the taken target, keeps the mask, and stores nothing. A later next-PC equal to its reconvergence address is therefore simply followed.
- R4: A branch whose effective taken mask is zero sends the PC to the fall-through address and keeps the mask.
- R5: A branch that splits the active threads sends the PC to the taken target and narrows the mask to the effective taken threads.
- R6: When the taken group of a split reaches the reconvergence address, the PC moves to the fall-through address and the mask becomes the threads that did not take the branch. The rejoin pulse is 1 for that cycle.
- R7: When the fall-through group then reaches the same reconvergence address, the PC equals that address, the mask returns to its value before the split, and the rejoin pulse is 1.
- R8: Nested splits unwind innermost first. Each reconvergence restores the mask of the level that encloses it.
- R9: A split that arrives while fewer than two stack slots are free sets the error flag. The flag stays set until reset. Nothing is stored, the PC goes to the taken target and the mask narrows to the taken threads.
- R10: Taken-mask bits of threads that are not active are ignored.
- R11: A branch presented in the same cycle as a next-PC value takes priority, and the next-PC value is ignored.
- R12: The active mask is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event this cycle |
| br_taken | input | WARP_SIZE | Per-thread taken bits |
| br_target | input | PC_W | Taken target address |
| br_fall | input | PC_W | Fall-through address |
| br_reconv | input | PC_W | Reconvergence address |
| npc_valid | input | 1 | Sequential next PC present |
| npc | input | PC_W | Sequential next PC |
| cur_pc | output | PC_W | Current warp PC |
| act_mask | output | WARP_SIZE | Active-thread mask |
| rejoin | output | 1 | Pulse: a stored context was restored |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
The hardest case to reach is overflow. It happens after two levels of nested splits have already filled the stack, and the mask at that point is a narrowed subset. The stimulus therefore builds a chain of nested splits with strictly shrinking taken masks, and the bench runs with a nesting depth of two. After the failed push, the bench checks two things: a later arrival at the unstored reconvergence address does not unwind the stack, and the enclosing level still unwinds correctly while the error flag stays set.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_ALL   = 2'd1,
    BK_ZERO  = 2'd2,
    BK_SPLIT = 2'd3
  } br_kind_e;
endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify
  import simt_div_pkg::*;
#(
  parameter int WARP_SIZE = 32
) (
  input  logic                 br_valid,
  input  logic [WARP_SIZE-1:0] taken_in,
  input  logic [WARP_SIZE-1:0] act_in,
  output br_kind_e             kind,
  output logic [WARP_SIZE-1:0] eff_taken,
  output logic [WARP_SIZE-1:0] rest_mask
);
  always_comb begin
    eff_taken = taken_in & act_in;
    rest_mask = act_in & ~eff_taken;
    if (!br_valid)                kind = BK_NONE;
    else if (eff_taken == '0)     kind = BK_ZERO;
    else if (eff_taken == act_in) kind = BK_ALL;
    else                          kind = BK_SPLIT;
  end
endmodule

// File: rtl/simt_entry_stack.sv
module simt_entry_stack #(
  parameter int ENT_W   = 97,
  parameter int ENTRIES = 8,
  localparam int SP_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push2,
  input  logic [ENT_W-1:0] push_lo,
  input  logic [ENT_W-1:0] push_hi,
  input  logic             pop,
  output logic [ENT_W-1:0] top_q,
  output logic             nonempty,
  output logic             no_room2
);
  logic [ENT_W-1:0] mem [ENTRIES];
  logic [SP_W-1:0]  sp;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push2) begin
      sp <= sp + SP_W'(2);
    end else if (pop && sp != '0) begin
      sp <= sp - SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (push2 && SP_W'(i) == sp)                 mem[i] <= push_lo;
      else if (push2 && SP_W'(i) == sp + SP_W'(1)) mem[i] <= push_hi;
    end
  end

  always_comb begin
    top_q = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (SP_W'(i + 1) == sp) top_q = mem[i];
    end
  end

  assign nonempty = (sp != '0);
  assign no_room2 = (32'(sp) + 2) > ENTRIES;
endmodule

// File: rtl/simt_reconv_match.sv
module simt_reconv_match #(
  parameter int PC_W = 32
) (
  input  logic            npc_valid,
  input  logic            br_valid,
  input  logic [PC_W-1:0] npc,
  input  logic [PC_W-1:0] cur_rpc,
  input  logic            cur_rv,
  input  logic            nonempty,
  output logic            hit
);
  assign hit = npc_valid && !br_valid && cur_rv && nonempty && (npc == cur_rpc);
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
  import simt_div_pkg::*;
#(
  parameter int WARP_SIZE   = 32,
  parameter int PC_W        = 32,
  parameter int NEST_DEPTH  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 br_valid,
  input  logic [WARP_SIZE-1:0] br_taken,
  input  logic [PC_W-1:0]      br_target,
  input  logic [PC_W-1:0]      br_fall,
  input  logic [PC_W-1:0]      br_reconv,
  input  logic                 npc_valid,
  input  logic [PC_W-1:0]      npc,
  output logic [PC_W-1:0]      cur_pc,
  output logic [WARP_SIZE-1:0] act_mask,
  output logic                 rejoin,
  output logic                 ovf_err
);
  localparam int ENTRIES = 2 * NEST_DEPTH;
  localparam int ENT_W   = 2 * PC_W + WARP_SIZE + 1;

  logic [PC_W-1:0]      cur_rpc;
  logic                 cur_rv;
  br_kind_e             kind;
  logic [WARP_SIZE-1:0] eff_taken, rest_mask;
  logic                 hit, nonempty, no_room2, push2;
  logic [ENT_W-1:0]     ent_join, ent_rest, top_q;
  logic [PC_W-1:0]      top_pc, top_rpc;
  logic [WARP_SIZE-1:0] top_mask;
  logic                 top_rv;

  simt_br_classify #(.WARP_SIZE(WARP_SIZE)) u_cls (
    .br_valid (br_valid),
    .taken_in (br_taken),
    .act_in   (act_mask),
    .kind     (kind),
    .eff_taken(eff_taken),
    .rest_mask(rest_mask)
  );

  simt_reconv_match #(.PC_W(PC_W)) u_match (
    .npc_valid(npc_valid),
    .br_valid (br_valid),
    .npc      (npc),
    .cur_rpc  (cur_rpc),
    .cur_rv   (cur_rv),
    .nonempty (nonempty),
    .hit      (hit)
  );

  assign push2    = (kind == BK_SPLIT) && !no_room2;
  assign ent_join = {br_reconv, act_mask, cur_rpc, cur_rv};
  assign ent_rest = {br_fall, rest_mask, br_reconv, 1'b1};
  assign {top_pc, top_mask, top_rpc, top_rv} = top_q;

  simt_entry_stack #(.ENT_W(ENT_W), .ENTRIES(ENTRIES)) u_stk (
    .clk     (clk),
    .rst     (rst),
    .push2   (push2),
    .push_lo (ent_join),
    .push_hi (ent_rest),
    .pop     (hit),
    .top_q   (top_q),
    .nonempty(nonempty),
    .no_room2(no_room2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pc   <= RESET_PC;
      act_mask <= '1;
      cur_rpc  <= '0;
      cur_rv   <= 1'b0;
      rejoin   <= 1'b0;
      ovf_err  <= 1'b0;
    end else begin
      rejoin <= 1'b0;
      case (kind)
        BK_ZERO: cur_pc <= br_fall;
        BK_ALL:  cur_pc <= br_target;
        BK_SPLIT: begin
          cur_pc   <= br_target;
          act_mask <= eff_taken;
          if (no_room2) begin
            ovf_err <= 1'b1;
          end else begin
            cur_rpc <= br_reconv;
            cur_rv  <= 1'b1;
          end
        end
        default: begin
          if (hit) begin
            cur_pc   <= top_pc;
            act_mask <= top_mask;
            cur_rpc  <= top_rpc;
            cur_rv   <= top_rv;
            rejoin   <= 1'b1;
          end else if (npc_valid) begin
            cur_pc <= npc;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/simt_div_stack_chk.sv
module simt_div_stack_chk #(
  parameter int WARP_SIZE = 32,
  parameter int PC_W      = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 br_valid,
  input logic                 npc_valid,
  input logic [PC_W-1:0]      npc,
  input logic [PC_W-1:0]      cur_pc,
  input logic [WARP_SIZE-1:0] act_mask,
  input logic                 rejoin,
  input logic                 ovf_err
);
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst) act_mask != '0); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_err |=> ovf_err); // R9
  AST_BR_SUBSET: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> ((act_mask & ~$past(act_mask)) == '0)); // R10
  AST_NPC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (npc_valid && !br_valid) |=> (rejoin || cur_pc == $past(npc))); // R2
  AST_REJOIN_SRC: assert property (@(posedge clk) disable iff (rst)
    rejoin |-> ($past(npc_valid) && !$past(br_valid))); // R6
  AST_BR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> !rejoin); // R11
endmodule

bind simt_div_stack simt_div_stack_chk #(.WARP_SIZE(WARP_SIZE), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .br_valid (br_valid),
  .npc_valid(npc_valid),
  .npc      (npc),
  .cur_pc   (cur_pc),
  .act_mask (act_mask),
  .rejoin   (rejoin),
  .ovf_err  (ovf_err)
);

// File: tb/sim_simt_div_stack.sv
`timescale 1ns/1ps
module sim_simt_div_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid = 1'b0;
  logic [31:0] br_taken = '0, br_target = '0, br_fall = '0, br_reconv = '0;
  logic        npc_valid = 1'b0;
  logic [31:0] npc = '0;
  logic [31:0] cur_pc, act_mask;
  logic        rejoin, ovf_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] mask;
    logic        hit;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  simt_div_stack #(.WARP_SIZE(32), .PC_W(32), .NEST_DEPTH(2)) u0 (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fall(br_fall), .br_reconv(br_reconv),
    .npc_valid(npc_valid), .npc(npc), .cur_pc(cur_pc), .act_mask(act_mask),
    .rejoin(rejoin), .ovf_err(ovf_err)
  );

  task automatic compare(input exp_t e);
    n_tests++;
    if (cur_pc !== e.pc || act_mask !== e.mask || rejoin !== e.hit || ovf_err !== e.err) begin
      n_fail++;
      $display("FAIL %s: pc=%h mask=%h hit=%b err=%b expected pc=%h mask=%h hit=%b err=%b",
               e.tag, cur_pc, act_mask, rejoin, ovf_err, e.pc, e.mask, e.hit, e.err);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  task automatic put(input logic bv, input logic [31:0] tk, input logic [31:0] tg,
                     input logic [31:0] fl, input logic [31:0] rc, input logic nv,
                     input logic [31:0] np, input logic [31:0] epc, input logic [31:0] emk,
                     input logic eh, input logic ee, input string tag);
    exp_t e;
    @(negedge clk);
    br_valid = bv; br_taken = tk; br_target = tg; br_fall = fl; br_reconv = rc;
    npc_valid = nv; npc = np;
    e.pc = epc; e.mask = emk; e.hit = eh; e.err = ee; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step_npc(input logic [31:0] np, input logic [31:0] epc,
                          input logic [31:0] emk, input logic eh, input logic ee,
                          input string tag);
    put(1'b0, '0, '0, '0, '0, 1'b1, np, epc, emk, eh, ee, tag);
  endtask

  task automatic step_br(input logic [31:0] tk, input logic [31:0] tg, input logic [31:0] fl,
                         input logic [31:0] rc, input logic [31:0] epc,
                         input logic [31:0] emk, input logic ee, input string tag);
    put(1'b1, tk, tg, fl, rc, 1'b0, '0, epc, emk, 1'b0, ee, tag);
  endtask

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    #2;
    r.pc = 32'h0; r.mask = ALL; r.hit = 1'b0; r.err = 1'b0; r.tag = "R1 reset";
    compare(r);
    @(negedge clk);
    rst = 1'b0;

    step_npc(32'h10, 32'h10, ALL, 0, 0, "R2 npc");
    step_npc(32'h14, 32'h14, ALL, 0, 0, "R2 npc");
    step_br(ALL, 32'h100, 32'h18, 32'h200, 32'h100, ALL, 0, "R3 uniform taken");
    step_npc(32'h200, 32'h200, ALL, 0, 0, "R3 no stored context");
    step_br(32'h0, 32'h300, 32'h204, 32'h400, 32'h204, ALL, 0, "R4 zero taken");
    put(1'b1, ALL, 32'h500, 32'h208, 32'h600, 1'b1, 32'h999, 32'h500, ALL, 0, 0, "R11 branch wins");
    step_br(32'h0000FFFF, 32'h600, 32'h504, 32'h700, 32'h600, 32'h0000FFFF, 0, "R5 split");
    step_npc(32'h604, 32'h604, 32'h0000FFFF, 0, 0, "R2 inside split");
    step_br(32'h000000FF, 32'h640, 32'h608, 32'h680, 32'h640, 32'h000000FF, 0, "R8 nested split");
    step_npc(32'h680, 32'h608, 32'h0000FF00, 1, 0, "R8 inner fall path");
    step_npc(32'h680, 32'h680, 32'h0000FFFF, 1, 0, "R8 inner rejoin");
    step_npc(32'h700, 32'h504, 32'hFFFF0000, 1, 0, "R6 outer fall path");
    step_npc(32'h508, 32'h508, 32'hFFFF0000, 0, 0, "R2 fall path");
    step_br(32'h00FF00FF, 32'h800, 32'h50C, 32'h900, 32'h800, 32'h00FF0000, 0, "R10 inactive bits ignored");
    step_npc(32'h900, 32'h50C, 32'hFF000000, 1, 0, "R6 rest of fall group");
    step_npc(32'h900, 32'h900, 32'hFFFF0000, 1, 0, "R7 inner join");
    step_npc(32'h700, 32'h700, ALL, 1, 0, "R7 full mask restored");
    step_npc(32'h700, 32'h700, ALL, 0, 0, "R12 no pop when empty");
    step_br(32'h0000FFFF, 32'hA00, 32'hA04, 32'hB00, 32'hA00, 32'h0000FFFF, 0, "R5 level one");
    step_br(32'h000000FF, 32'hA40, 32'hA44, 32'hA80, 32'hA40, 32'h000000FF, 0, "R5 level two");
    step_br(32'h0000000F, 32'hA50, 32'hA54, 32'hA60, 32'hA50, 32'h0000000F, 1, "R9 overflow");
    step_npc(32'hA60, 32'hA60, 32'h0000000F, 0, 1, "R9 nothing stored");
    step_npc(32'hA80, 32'hA44, 32'h0000FF00, 1, 1, "R9 sticky, enclosing unwinds");

    @(negedge clk);
    br_valid = 1'b0; npc_valid = 1'b0;
    wait (sb.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    r.pc = 32'h0; r.mask = ALL; r.hit = 1'b0; r.err = 1'b0; r.tag = "R1 reset clears error";
    compare(r);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule